// File: doc/BRIEF.md
# Quadrature Encoder Emulation Generator

This block converts the update strobes of a position-tracking loop into the signals of an incremental encoder. Each single-cycle strobe moves a wrapping 12-bit position count by one step. The step goes up or down according to a direction level that is sampled with the strobe. The two channel outputs are a Gray-coded image of the two lowest count bits, so four updates make one full channel cycle. A full turn of the count therefore produces 1024 channel cycles.

An index marker is raised while the count sits in a window that begins at zero. The window is one, two or four positions wide, chosen by a two-bit select. A registered direction output reports the sense of the most recent update. The outputs run freely and always reflect the current count. A downstream 4x decoder, or a direct up/down counter that uses the direction output, can rebuild the angle from them.

Top module: `quad_encoder_emulator`

## Requirements
- R1: While reset is high and after it is released without strobes, the position is 0, enc_a_o and enc_b_o are 0, index_o is 1 (count 0 is inside every window) and dir_o is 1.
- R2: A strobe with dir_up_i=1 adds one to the position. The pair (enc_a_o, enc_b_o) follows the low two count bits: 00 gives (0,0), 01 gives (0,1), 10 gives (1,1) and 11 gives (1,0). B therefore leads A when the angle increases.
- R3: A strobe with dir_up_i=0 subtracts one from the position, so the channel sequence runs backwards and A leads B.
- R4: Without a strobe, the position and all outputs hold, whatever dir_up_i does.
- R5: The position wraps modulo 4096 in both directions: 4095 plus one gives 0, and 0 minus one gives 4095.
- R6: With width_sel_i=2'b00 (quarter cycle), index_o is high only at count 0.
- R7: With width_sel_i=2'b01 (half cycle), index_o is high at counts 0 and 1 only.
- R8: With width_sel_i=2'b10 (full cycle), index_o is high at counts 0 to 3 only.
- R9: width_sel_i=2'b11 behaves like 2'b00.
- R10: dir_o takes the value of dir_up_i at each strobe edge and holds it between strobes.
- R11: The count and dir_o change on the strobe edge. enc_a_o, enc_b_o and index_o change on the next clock edge.
- R12: From one clock to the next, at most one of enc_a_o and enc_b_o toggles. A full turn of 4096 strobes yields 1024 rising edges on enc_a_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Single-cycle position update strobe |
| dir_up_i | input | 1 | 1 = increase position, 0 = decrease; sampled with step_i |
| width_sel_i | input | 2 | Index width: 00 quarter, 01 half, 10 full, 11 quarter |
| enc_a_o | output | 1 | Channel A |
| enc_b_o | output | 1 | Channel B |
| index_o | output | 1 | Index marker, window starting at count 0 |
| dir_o | output | 1 | Registered direction of the last update |

## Verification
Two functions can meet in one cycle: a wrap of the count across zero, and a change of the index window. The bench provokes this by reversing direction exactly at zero, so the decrement to 4095 must drop the marker on the same edge that the channels move to the last Gray state. It also steps through zero under each window width while the select is changed between updates. In each case the channels and the marker are judged one edge after the strobe against a position model kept in the bench. The direction output is judged on the strobe edge itself.

// File: rtl/qe_pkg.sv
package qe_pkg;

    typedef enum logic [1:0] {
        MW_QUARTER = 2'b00,
        MW_HALF    = 2'b01,
        MW_FULL    = 2'b10,
        MW_SPARE   = 2'b11
    } mark_width_e;

    typedef struct packed {
        logic a;
        logic b;
        logic mark;
    } enc_sig_t;

    localparam enc_sig_t ENC_RESET = '{a: 1'b0, b: 1'b0, mark: 1'b1};

    // number of low positions covered by the index window
    function automatic logic [2:0] mark_span(input mark_width_e w);
        case (w)
            MW_HALF: return 3'd2;
            MW_FULL: return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

    // Gray image of the two lowest position bits: {a, b}
    function automatic logic [1:0] phase_of(input logic [1:0] lo);
        return {lo[1], lo[1] ^ lo[0]};
    endfunction

endpackage

// File: rtl/qe_position_counter.sv
module qe_position_counter #(
    parameter int POS_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    input  logic             dir_up_i,
    output logic [POS_W-1:0] pos_o
);
    localparam logic [POS_W-1:0] ONE = {{(POS_W-1){1'b0}}, 1'b1};

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_d;

    always_comb begin
        pos_d = pos_q;
        if (step_i) begin
            pos_d = dir_up_i ? (pos_q + ONE) : (pos_q - ONE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pos_q <= '0;
        else     pos_q <= pos_d;
    end

    assign pos_o = pos_q;
endmodule

// File: rtl/qe_phase_decoder.sv
module qe_phase_decoder
    import qe_pkg::*;
#(
    parameter int POS_W = 12
) (
    input  logic [POS_W-1:0] pos_i,
    input  logic [1:0]       width_sel_i,
    output enc_sig_t         sig_o
);
    localparam int HI_W = POS_W - 2;

    logic [1:0]  ab;
    logic        upper_zero;
    logic [2:0]  span;

    always_comb begin
        ab         = phase_of(pos_i[1:0]);
        upper_zero = (pos_i[POS_W-1:2] == {HI_W{1'b0}});
        span       = mark_span(mark_width_e'(width_sel_i));
        sig_o.a    = ab[1];
        sig_o.b    = ab[0];
        sig_o.mark = upper_zero && ({1'b0, pos_i[1:0]} < span);
    end
endmodule

// File: rtl/qe_output_stage.sv
module qe_output_stage
    import qe_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  enc_sig_t sig_i,
    input  logic     step_i,
    input  logic     dir_up_i,
    output enc_sig_t sig_o,
    output logic     dir_o
);
    enc_sig_t sig_q;
    logic     dir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sig_q <= ENC_RESET;
            dir_q <= 1'b1;
        end else begin
            sig_q <= sig_i;
            if (step_i) dir_q <= dir_up_i;
        end
    end

    assign sig_o = sig_q;
    assign dir_o = dir_q;
endmodule

// File: rtl/quad_encoder_emulator.sv
module quad_encoder_emulator
    import qe_pkg::*;
#(
    parameter int POS_W = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       step_i,
    input  logic       dir_up_i,
    input  logic [1:0] width_sel_i,
    output logic       enc_a_o,
    output logic       enc_b_o,
    output logic       index_o,
    output logic       dir_o
);
    logic [POS_W-1:0] pos_q;
    enc_sig_t         sig_comb;
    enc_sig_t         sig_reg;

    qe_position_counter #(.POS_W(POS_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .step_i   (step_i),
        .dir_up_i (dir_up_i),
        .pos_o    (pos_q)
    );

    qe_phase_decoder #(.POS_W(POS_W)) u_dec (
        .pos_i       (pos_q),
        .width_sel_i (width_sel_i),
        .sig_o       (sig_comb)
    );

    qe_output_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .sig_i    (sig_comb),
        .step_i   (step_i),
        .dir_up_i (dir_up_i),
        .sig_o    (sig_reg),
        .dir_o    (dir_o)
    );

    assign enc_a_o = sig_reg.a;
    assign enc_b_o = sig_reg.b;
    assign index_o = sig_reg.mark;
endmodule

// File: rtl/qe_checker.sv
module qe_checker #(
    parameter int POS_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             step_i,
    input logic             dir_up_i,
    input logic [POS_W-1:0] pos_q,
    input logic             enc_a_o,
    input logic             enc_b_o,
    input logic             index_o,
    input logic             dir_o
);
    localparam logic [POS_W-1:0] ONE = {{(POS_W-1){1'b0}}, 1'b1};

    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> $stable(pos_q)) else $error("hold");                        // R4

    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
        (step_i && dir_up_i) |=> pos_q == $past(pos_q) + ONE) else $error("up"); // R2

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (step_i && !dir_up_i) |=> pos_q == $past(pos_q) - ONE) else $error("dn"); // R3

    AST_DIR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        step_i |=> dir_o == $past(dir_up_i)) else $error("dir");                 // R10

    AST_A_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        enc_a_o == $past(pos_q[1])) else $error("a lag");                        // R11

    AST_ONE_EDGE: assert property (@(posedge clk) disable iff (rst)
        $countones({enc_a_o, enc_b_o} ^ $past({enc_a_o, enc_b_o})) <= 1)
        else $error("two edges");                                                // R12

    AST_MARK_NEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        index_o |-> $past(pos_q[POS_W-1:2]) == '0) else $error("mark");          // R8
endmodule

bind quad_encoder_emulator qe_checker #(.POS_W(POS_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .step_i   (step_i),
    .dir_up_i (dir_up_i),
    .pos_q    (pos_q),
    .enc_a_o  (enc_a_o),
    .enc_b_o  (enc_b_o),
    .index_o  (index_o),
    .dir_o    (dir_o)
);

// File: tb/test_quad_encoder_emulator.sv
`timescale 1ns/1ps
module test_quad_encoder_emulator;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_i = 1'b0;
    logic       dir_up_i = 1'b1;
    logic [1:0] width_sel_i = 2'b00;
    logic       enc_a_o, enc_b_o, index_o, dir_o;

    int checks = 0;
    int errors = 0;
    int model_pos = 0;

    always #5 clk = ~clk;

    quad_encoder_emulator i_quad_encoder_emulator (
        .clk(clk), .rst(rst), .step_i(step_i), .dir_up_i(dir_up_i),
        .width_sel_i(width_sel_i), .enc_a_o(enc_a_o), .enc_b_o(enc_b_o),
        .index_o(index_o), .dir_o(dir_o)
    );

    function automatic logic [1:0] exp_ab(input int p);
        logic [1:0] lo;
        lo = p[1:0];
        return {lo[1], lo[1] ^ lo[0]};
    endfunction

    function automatic logic exp_mark(input int p, input logic [1:0] sel);
        int span;
        span = (sel == 2'b01) ? 2 : (sel == 2'b10) ? 4 : 1;
        return p < span;
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_outs(input string tag);
        check({enc_a_o, enc_b_o} == exp_ab(model_pos), {tag, " AB"},
              {enc_a_o, enc_b_o}, exp_ab(model_pos));
        check(index_o == exp_mark(model_pos, width_sel_i), {tag, " mark"},
              index_o, exp_mark(model_pos, width_sel_i));
    endtask

    // strobe one cycle, then wait so that registered outputs have settled
    task automatic step_settle(input logic up);
        @(negedge clk); step_i = 1'b1; dir_up_i = up;
        @(negedge clk); step_i = 1'b0;
        model_pos = up ? (model_pos + 1) % 4096 : (model_pos + 4095) % 4096;
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1; step_i = 1'b0; width_sel_i = 2'b00; dir_up_i = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0; model_pos = 0;
        @(negedge clk);
        check({enc_a_o, enc_b_o, index_o, dir_o} == 4'b0011, "R1 reset outputs",
              {enc_a_o, enc_b_o, index_o, dir_o}, 4'b0011);
    endtask

    task automatic t_up_gray;
        t_reset();
        for (int i = 0; i < 8; i++) begin
            step_settle(1'b1);
            check_outs("R2 up sequence");
        end
    endtask

    task automatic t_down_gray;
        t_reset();
        for (int i = 0; i < 6; i++) step_settle(1'b1);
        for (int i = 0; i < 5; i++) begin
            step_settle(1'b0);
            check_outs("R3 down sequence");
            check(dir_o == 1'b0, "R10 dir low", dir_o, 0);
        end
    endtask

    task automatic t_hold;
        logic [3:0] snap;
        t_reset();
        step_settle(1'b1); step_settle(1'b1);
        snap = {enc_a_o, enc_b_o, index_o, dir_o};
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); dir_up_i = ~dir_up_i;
        end
        @(negedge clk);
        check({enc_a_o, enc_b_o, index_o, dir_o} == snap, "R4 hold without strobe",
              {enc_a_o, enc_b_o, index_o, dir_o}, snap);
        step_settle(1'b1);
        check_outs("R4 count kept through idle");
    endtask

    task automatic t_latency;
        t_reset();
        @(negedge clk); step_i = 1'b1; dir_up_i = 1'b0;
        @(negedge clk); step_i = 1'b0;
        check(dir_o == 1'b0, "R11 dir on strobe edge", dir_o, 0);
        check({enc_a_o, enc_b_o, index_o} == 3'b001, "R11 channels not yet moved",
              {enc_a_o, enc_b_o, index_o}, 3'b001);
        @(negedge clk);
        check({enc_a_o, enc_b_o, index_o} == 3'b100, "R11 channels one edge later",
              {enc_a_o, enc_b_o, index_o}, 3'b100);
        model_pos = 4095;
    endtask

    task automatic t_wrap;
        t_reset();
        step_settle(1'b0);
        check_outs("R5 wrap below zero");
        step_settle(1'b1);
        check_outs("R5 wrap back to zero");
        width_sel_i = 2'b10;
        step_settle(1'b0);
        check(index_o == 1'b0, "R5 R8 full window off at 4095", index_o, 0);
    endtask

    task automatic t_windows;
        for (int s = 0; s < 4; s++) begin
            t_reset();
            width_sel_i = s[1:0];
            @(negedge clk);
            check_outs("R6 R7 R8 R9 window at zero");
            for (int i = 0; i < 5; i++) begin
                step_settle(1'b1);
                check_outs("R6 R7 R8 R9 window up");
            end
            for (int i = 0; i < 6; i++) begin
                step_settle(1'b0);
                check_outs("R6 R7 R8 R9 window down through zero");
            end
        end
    endtask

    task automatic t_revolution;
        int rises = 0;
        int bad = 0;
        logic prev_a;
        t_reset();
        prev_a = enc_a_o;
        for (int i = 0; i < 4096; i++) begin
            step_settle(1'b1);
            if ({enc_a_o, enc_b_o} != exp_ab(model_pos)) bad++;
            if (enc_a_o && !prev_a) rises++;
            prev_a = enc_a_o;
        end
        check(bad == 0, "R12 channel mismatches over a turn", bad, 0);
        check(rises == 1024, "R12 A rises per turn", rises, 1024);
        check(index_o == 1'b1, "R5 back at zero after a turn", index_o, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_up_gray();
        t_down_gray();
        t_hold();
        t_latency();
        t_wrap();
        t_windows();
        t_revolution();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule